// File: doc/BRIEF.md
# Staged Duty Register with Pulse-Width Generator

This block puts a pulse-width modulator behind a narrow byte-wide register bus. The duty value is wider than the bus, so software delivers it as two writes. The low part goes into a holding register, and nothing downstream sees it yet. The write of the high part joins the new high bits with the held low part and hands the whole value to the generator in one clock. The generator therefore never runs on a value that mixes old and new halves.

The generator counts through a period of 2^DUTY_W clocks. It holds its output high for as many clocks as the active duty value and low for the rest of the period. A newly handed-over value is adopted only when the counter wraps, so a period that is already running always finishes on the value it began with.

A third bus address holds a per-module standby bit. Clearing it freezes the counter where it stands and forces the output low. The duty value is kept, and setting the bit again resumes counting from the same position.

Top module: `duty_pwm`

## Requirements
- R1: After reset the output is low and stays low through a whole period, and every address reads all ones. Reset leaves the held low part at zero, the active duty value at zero and the standby bit at 1 (running).
- R2: The data addresses are write-only. A read at select 0 (low part), select 1 (high part) or the spare select 3 returns all ones at any time.
- R3: A write at select 0 only loads the holding register. Without a later select-1 write, the output stays as it was.
- R4: A write at select 1 hands the generator the value {wdata[DUTY_W-BUS_W-1:0], held low part} in a single clock. Write-data bits at and above position DUTY_W-BUS_W are ignored.
- R5: With active value D, each period of 2^DUTY_W running clocks has the output high for exactly D clocks, at counter positions 0 to D-1, and low for the rest.
- R6: A value handed over mid-period takes effect only at the counter wrap. The rest of the current period follows the old value.
- R7: Select 2 is the standby register. Bit STOP_BIT is readable and writable, and 1 means run while 0 means stop. Every other bit reads 1 and ignores writes.
- R8: While stopped, the counter holds its position and the output is low. After resuming, counting continues from the held position with the kept duty value.
- R9: A second select-1 write with no select-0 write in between reuses the previously held low part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus registers and the generator |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 low part, 1 high part, 2 standby, 3 spare |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the current select (combinational) |
| pwm_out | output | 1 | Pulse-width modulated output |

## Verification
The bench builds the block with BUS_W = 4, DUTY_W = 6 and STOP_BIT = 1. That gives a 2-bit high part and a 64-clock period, so many full periods, wrap-time hand-overs and stop/resume positions fit in a short run. The narrow high part also makes the ignored upper write bits of R4 easy to exercise. The register-level rules depend only on the widths, so the same checks apply to the default 8/14-bit build.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

   // Register selects on the byte bus
   typedef enum logic [1:0] {
      SEL_LO    = 2'd0,
      SEL_HI    = 2'd1,
      SEL_STOP  = 2'd2,
      SEL_SPARE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/duty_pwm_regs.sv
module duty_pwm_regs
   import duty_pwm_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int DUTY_W   = 14,
   parameter int STOP_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [DUTY_W-1:0] duty_cmt,
   output logic              run
);

   localparam int HI_W = DUTY_W - BUS_W;

   reg_sel_e            sel;
   logic [BUS_W-1:0]    stage_q;
   logic [DUTY_W-1:0]   cmt_q;
   logic                run_q;
   logic [BUS_W-1:0]    stop_word;

   assign sel = reg_sel_e'(bus_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cmt_q   <= '0;
         run_q   <= 1'b1;
      end else if (bus_wr) begin
         case (sel)
            SEL_LO:   stage_q <= bus_wdata;
            SEL_HI:   cmt_q   <= {bus_wdata[HI_W-1:0], stage_q};
            SEL_STOP: run_q   <= bus_wdata[STOP_BIT];
            default:  ;
         endcase
      end
   end

   // Standby register image: only the module's own bit is stored
   for (genvar i = 0; i < BUS_W; i++) begin : g_stop_bit
      if (i == STOP_BIT) begin : g_live
         assign stop_word[i] = run_q;
      end else begin : g_fixed
         assign stop_word[i] = 1'b1;
      end
   end

   assign bus_rdata = (sel == SEL_STOP) ? stop_word : '1;
   assign duty_cmt  = cmt_q;
   assign run       = run_q;

   // R3: a low-part write never moves the handed-over value
   assert_low_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_LO) |=> $stable(duty_cmt));

   // R4: high-part write joins its low bits with the held low part
   assert_commit_join_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_HI) |=>
         duty_cmt == {$past(bus_wdata[HI_W-1:0]), $past(stage_q)});

   // R7: standby bit follows a write to its own position
   assert_stop_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_STOP) |=> run == $past(bus_wdata[STOP_BIT]));

endmodule

// File: rtl/duty_pwm_gen.sv
module duty_pwm_gen #(
   parameter int DUTY_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DUTY_W-1:0] duty_cmt,
   output logic              pwm_out
);

   localparam logic [DUTY_W-1:0] CNT_MAX = '1;

   logic [DUTY_W-1:0] cnt_q;
   logic [DUTY_W-1:0] act_q;
   logic              wrap;

   assign wrap = (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (run) begin
         if (wrap) begin
            cnt_q <= '0;
            act_q <= duty_cmt;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm_out = run && (cnt_q < act_q);

   // R8: stopped means output low
   assert_low_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !pwm_out);

   // R8: stopped counter holds its position
   assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q));

   // R6: the active value changes only across a running wrap
   assert_adopt_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> ($past(cnt_q) == CNT_MAX && $past(run)));

endmodule

// File: rtl/duty_pwm.sv
module duty_pwm #(
   parameter int BUS_W    = 8,
   parameter int DUTY_W   = 14,
   parameter int STOP_BIT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_sel,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             pwm_out
);

   if (DUTY_W <= BUS_W) begin : g_bad_width
      $error("duty_pwm: DUTY_W must exceed BUS_W");
   end
   if (DUTY_W > 2 * BUS_W) begin : g_bad_split
      $error("duty_pwm: DUTY_W must fit in two bus words");
   end
   if (STOP_BIT < 0 || STOP_BIT >= BUS_W) begin : g_bad_stop
      $error("duty_pwm: STOP_BIT outside the bus word");
   end

   logic [DUTY_W-1:0] duty_cmt;
   logic              run;

   duty_pwm_regs #(
      .BUS_W    (BUS_W),
      .DUTY_W   (DUTY_W),
      .STOP_BIT (STOP_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .duty_cmt  (duty_cmt),
      .run       (run)
   );

   duty_pwm_gen #(
      .DUTY_W (DUTY_W)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .duty_cmt (duty_cmt),
      .pwm_out  (pwm_out)
   );

   // R2: data and spare selects always read all ones
   assert_data_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel != 2'd2) |-> (bus_rdata == {BUS_W{1'b1}}));

endmodule

// File: tb/duty_pwm_bench.sv
module duty_pwm_bench;

   localparam int CLK_P    = 10;
   localparam int BUS_W    = 4;
   localparam int DUTY_W   = 6;
   localparam int STOP_BIT = 1;
   localparam int HI_W     = DUTY_W - BUS_W;
   localparam int PERIOD   = 1 << DUTY_W;
   localparam int ONES     = (1 << BUS_W) - 1;
   localparam int WD_LIMIT = 50000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       bus_sel = 2'd0;
   logic             bus_wr = 1'b0;
   logic [BUS_W-1:0] bus_wdata = '0;
   logic [BUS_W-1:0] bus_rdata;
   logic             pwm_out;

   int n_checks = 0;
   int n_fail   = 0;

   // reference model state
   int m_cnt = 0, m_act = 0, m_cmt = 0, m_stage = 0;
   bit m_run = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   duty_pwm #(
      .BUS_W    (BUS_W),
      .DUTY_W   (DUTY_W),
      .STOP_BIT (STOP_BIT)
   ) u_duty_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // Behavioural model, compared a quarter period after every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_act = 0; m_cmt = 0; m_stage = 0; m_run = 1'b1;
      end else begin
         if (m_run) begin
            if (m_cnt == PERIOD - 1) begin
               m_cnt = 0;
               m_act = m_cmt;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         if (bus_wr) begin
            case (bus_sel)
               2'd0: m_stage = int'(bus_wdata);
               2'd1: m_cmt = (int'(bus_wdata) % (1 << HI_W)) * (1 << BUS_W) + m_stage;
               2'd2: m_run = bus_wdata[STOP_BIT];
               default: ;
            endcase
         end
      end
      #(CLK_P/4);
      if (rst_n) begin
         chk("R5 output vs model", int'(pwm_out), (m_run && m_cnt < m_act) ? 1 : 0);
         if (bus_sel == 2'd2)
            chk("R7 standby read vs model", int'(bus_rdata),
                (ONES & ~(1 << STOP_BIT)) | (int'(m_run) << STOP_BIT));
         else
            chk("R2 data read vs model", int'(bus_rdata), ONES);
      end
   end

   task automatic bus_write(input int s, input int d);
      bus_sel   = 2'(s);
      bus_wdata = BUS_W'(d);
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic read_reg(input int s, output int v);
      bus_sel = 2'(s);
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic count_high(input int cycles, output int n);
      n = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (pwm_out) n++;
      end
   endtask

   // watchdog
   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d cycles", WD_LIMIT, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 output after reset", int'(pwm_out), 0);
      for (int s = 0; s < 4; s++) begin
         read_reg(s, v);
         chk("R1 read after reset", v, ONES);
      end
      count_high(PERIOD + 2, n);
      chk("R1 no pulse with reset duty", n, 0);

      // R3: low-part write alone
      bus_write(0, 5);
      count_high(2 * PERIOD, n);
      chk("R3 low write leaves output", n, 0);

      // R4: commit with upper write bits set (only low HI_W bits count)
      bus_write(1, 4'hE);
      repeat (PERIOD) @(negedge clk);
      count_high(PERIOD, n);
      chk("R4 committed duty 37", n, 37);
      read_reg(0, v);
      chk("R2 low part reads ones", v, ONES);
      read_reg(1, v);
      chk("R2 high part reads ones", v, ONES);

      // R6: hand over at the falling edge, old period must finish low
      bus_write(0, 2);
      while (!pwm_out) @(negedge clk);
      while (pwm_out) @(negedge clk);
      bus_sel = 2'd1; bus_wdata = BUS_W'(3); bus_wr = 1'b1;
      n = 0;
      while (!pwm_out) begin
         n++;
         @(negedge clk);
         bus_wr = 1'b0;
      end
      chk("R6 old period finishes", n, PERIOD - 37);
      count_high(PERIOD, n);
      chk("R6 new duty 50", n, 50);

      // R9: high write reuses held low part
      bus_write(1, 1);
      repeat (PERIOD) @(negedge clk);
      count_high(PERIOD, n);
      chk("R9 reused low part duty 18", n, 18);

      // R8 / R7: stop at counter position 0
      while (pwm_out) @(negedge clk);
      while (!pwm_out) @(negedge clk);
      bus_write(2, 0);
      read_reg(2, v);
      chk("R7 standby bit cleared, others one", v, ONES & ~(1 << STOP_BIT));
      count_high(100, n);
      chk("R8 output low while stopped", n, 0);
      bus_write(2, 1 << STOP_BIT);
      n = 0;
      while (pwm_out) begin
         n++;
         @(negedge clk);
      end
      chk("R8 resume from held position", n, 17);
      read_reg(2, v);
      chk("R7 standby bit set", v, ONES);
      count_high(PERIOD, n);
      chk("R8 duty kept after stop", n, 18);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule